// File: doc/BRIEF.md
# Flash Command Interface Controller

This block sits between a processor's parallel byte bus and a byte-wide non-volatile array model. Every bus write is taken as a command byte. The command selects what bus reads return: array bytes, the two identifier codes, or the status byte. Commands also start the two content-altering operations. Block erase needs a setup command followed by a confirm byte. Byte program needs a setup command followed by a write that carries the destination address and the data. Once an operation is started, an internal write state machine runs it on its own. The processor polls the status byte to see when the operation is finished and whether it failed.

Erase walks the whole address range one byte per cycle and sets every byte of the target block to `0xFF`. Program works the way a real cell does and can only clear bits. Each timed pulse clears the lowest bit that still differs from the target value. After each pulse an internal verify compares the byte with the target. Pulses repeat until the byte matches or the retry budget runs out. An erase can be suspended so that other blocks can be read, and it can later be resumed. Changes to the array are gated by a program-voltage-valid input, a supply-ok input and an active-low powerdown pin.

The states of the write state machine are:
- `ST_IDLE`. Read commands and clear-status are accepted here.
- `ST_ERASE_SETUP` and `ST_PROG_SETUP`. Each waits for its second write.
- `ST_ERASING`. The cursor walks the array.
- `ST_ERASE_SUSP`. The erase is paused.
- `ST_PROG_PULSE` and `ST_PROG_VERIFY`.

The transitions are:
- IDLE→ERASE_SETUP on `0x20`.
- IDLE→PROG_SETUP on `0x40`.
- ERASE_SETUP→ERASING on `0xD0` with good voltage. Any other second write goes back to IDLE with an error.
- PROG_SETUP→PROG_PULSE on the data write. The data write goes back to IDLE with an error if the voltage is low.
- ERASING→ERASE_SUSP on `0xB0`, and ERASE_SUSP→ERASING on `0xD0`.
- ERASING→IDLE at the last address, or on loss of voltage.
- PROG_PULSE→PROG_VERIFY when a pulse ends.
- PROG_VERIFY→IDLE on a match or when the retry budget is used up. PROG_VERIFY→PROG_PULSE otherwise.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, and after `pwd_n` returns high, the read mode is array data and the status byte is `0x80`.
- R2: The command `0x90` selects identifier reads: address bit 0 = 0 gives the maker code `0x5A`, and address bit 0 = 1 gives the device code (`0x3C` top-boot, `0x3D` bottom-boot). `0x70` selects status reads, and `0xFF` selects array reads.
- R3: An erase starts only after `0x20` is followed directly by `0xD0`. Any other second byte leaves the array unchanged, sets status bit 5 (erase error) and returns to idle.
- R4: A confirmed erase sets every byte of the block containing the confirm address to `0xFF` and leaves all other bytes unchanged. Status bit 7 (ready) is 0 until the erase finishes.
- R5: With top-boot layout, the array splits into blocks as follows, in sixteenths or thirty-seconds of the address space. The upper 1/16 is the boot block. The two 1/32 slices below it are separate parameter blocks. Everything else is the main block.
- R6: `0x40` followed by a write of address A and data D makes byte A equal to (old AND D). Ready is 0 while the operation runs, and the status afterwards is `0x80`.
- R7: Each program pulse clears one differing bit, and the byte is verified after every pulse. If D needs a 0 turned into a 1, the operation ends after 8 pulses with status bit 4 (program error) set and the byte equal to (old AND D). Clearing all 8 bits succeeds.
- R8: With `vpp_ok` low at the confirm or data write, the array is unchanged. Status bit 3 (voltage error) is set together with bit 5 (erase) or bit 4 (program). Identifier and status reads still work.
- R9: If `vpp_ok` falls during an erase, the erase stops with bits 3 and 5 set and ready = 1.
- R10: While `pwd_n` is low, `bus_rdata` is 0 and writes are ignored. Any running operation is abandoned without raising an error.
- R11: While `vcc_ok` is low, bus writes have no effect on the mode or the state.
- R12: `0xB0` during an erase gives status `0xC0` (ready and suspended) and freezes erase progress. Array reads of other blocks are allowed while suspended. `0xD0` resumes the erase, which then completes.
- R13: Error bits 5, 4 and 3 stay set across other commands until `0x50` is written in idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwd_n | input | 1 | Active-low powerdown; clears state synchronously and silences reads |
| vpp_ok | input | 1 | Program voltage valid |
| vcc_ok | input | 1 | Supply above write-lockout level |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_we | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata | input | 8 | Command byte or program data |
| bus_rdata | output | 8 | Array byte, identifier code or status, depending on the read mode |

## Verification
The hardest situation to reach is a suspended erase whose cursor sits partway through the main block. Its frozen progress is only visible as a main-block byte that has not yet turned to `0xFF` long after a full erase would have ended. The bench fills the whole array with a distinct pattern through 1024 program operations. It then starts a main-block erase, suspends it 50 cycles in, and waits 2000 cycles. Next it reads a high main-block byte and a boot-block byte. Finally it resumes and sweeps every address. The same full-array sweep after each block erase checks the block boundaries exhaustively.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

    localparam int DW = 8;

    localparam logic [DW-1:0] OP_READ_ARRAY  = 8'hFF;
    localparam logic [DW-1:0] OP_READ_IDENT  = 8'h90;
    localparam logic [DW-1:0] OP_READ_STATUS = 8'h70;
    localparam logic [DW-1:0] OP_CLEAR_STAT  = 8'h50;
    localparam logic [DW-1:0] OP_ERASE_SETUP = 8'h20;
    localparam logic [DW-1:0] OP_CONFIRM     = 8'hD0;
    localparam logic [DW-1:0] OP_PROG_SETUP  = 8'h40;
    localparam logic [DW-1:0] OP_SUSPEND     = 8'hB0;

    typedef enum logic [1:0] {
        BLK_MAIN, BLK_PARAM_LO, BLK_PARAM_HI, BLK_BOOT
    } blk_e;

    typedef enum logic [1:0] {
        RD_ARRAY, RD_IDENT, RD_STATUS
    } rd_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ERASE_SETUP, ST_PROG_SETUP, ST_ERASING,
        ST_ERASE_SUSP, ST_PROG_PULSE, ST_PROG_VERIFY
    } wsm_state_e;

endpackage

// File: rtl/fcc_block_decode.sv
module fcc_block_decode
    import fcc_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter bit TOP_BOOT = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    output blk_e              blk
);
    localparam int HB = ADDR_W - 1;

    logic [3:0] upper4;
    logic       slice_bit;

    assign upper4    = addr[HB -: 4];
    assign slice_bit = addr[HB-4];

    generate
        if (TOP_BOOT) begin : g_top_boot
            always_comb begin
                if (upper4 == 4'hF)      blk = BLK_BOOT;
                else if (upper4 == 4'hE) blk = slice_bit ? BLK_PARAM_HI : BLK_PARAM_LO;
                else                     blk = BLK_MAIN;
            end
        end else begin : g_bottom_boot
            always_comb begin
                if (upper4 == 4'h0)      blk = BLK_BOOT;
                else if (upper4 == 4'h1) blk = slice_bit ? BLK_PARAM_HI : BLK_PARAM_LO;
                else                     blk = BLK_MAIN;
            end
        end
    endgenerate

endmodule

// File: rtl/fcc_array.sv
module fcc_array
    import fcc_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    input  logic [ADDR_W-1:0] op_addr,
    output logic [DW-1:0]     op_data,
    input  logic              wr_en,
    input  logic [DW-1:0]     wr_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) cells[op_addr] <= wr_data;
    end

    assign rd_data = cells[rd_addr];
    assign op_data = cells[op_addr];

endmodule

// File: rtl/fcc_wsm.sv
module fcc_wsm
    import fcc_pkg::*;
#(
    parameter int ADDR_W       = 10,
    parameter int PULSE_CYCLES = 3,
    parameter int MAX_PULSES   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwd_n,
    input  logic              vpp_ok,
    input  logic              vcc_ok,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  blk_e              addr_blk,
    input  blk_e              cur_blk,
    input  logic [DW-1:0]     op_data,
    output logic [ADDR_W-1:0] op_addr,
    output logic              wr_en,
    output logic [DW-1:0]     wr_data,
    output rd_mode_e          rd_mode,
    output logic [DW-1:0]     status
);
    localparam int TIMER_W = $clog2(PULSE_CYCLES + 1);
    localparam int CNT_W   = $clog2(MAX_PULSES + 1);

    wsm_state_e        state_q, state_d;
    rd_mode_e          mode_q, mode_d;
    blk_e              target_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DW-1:0]     goal_q;
    logic [TIMER_W-1:0] timer_q;
    logic [CNT_W-1:0]  pulses_q;
    logic err_erase_q, err_prog_q, err_vpp_q;

    logic we_ok, timer_last, erase_last;
    logic set_erase_err, set_prog_err, set_vpp_err, clr_err;
    logic start_erase, start_prog, pulse_fire;
    logic [DW-1:0] pending, low_bit;

    assign we_ok      = bus_we && vcc_ok;
    assign timer_last = (timer_q == TIMER_W'(PULSE_CYCLES - 1));
    assign erase_last = (addr_q == '1);

    always_comb begin
        state_d = state_q;
        mode_d  = mode_q;
        set_erase_err = 1'b0;
        set_prog_err  = 1'b0;
        set_vpp_err   = 1'b0;
        clr_err       = 1'b0;
        start_erase   = 1'b0;
        start_prog    = 1'b0;
        pulse_fire    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (we_ok) begin
                    case (bus_wdata)
                        OP_ERASE_SETUP: begin state_d = ST_ERASE_SETUP; mode_d = RD_STATUS; end
                        OP_PROG_SETUP:  begin state_d = ST_PROG_SETUP;  mode_d = RD_STATUS; end
                        OP_READ_ARRAY:  mode_d  = RD_ARRAY;
                        OP_READ_IDENT:  mode_d  = RD_IDENT;
                        OP_READ_STATUS: mode_d  = RD_STATUS;
                        OP_CLEAR_STAT:  clr_err = 1'b1;
                        default: ;
                    endcase
                end
            end
            ST_ERASE_SETUP: begin
                if (we_ok) begin
                    state_d = ST_IDLE;
                    if (bus_wdata != OP_CONFIRM) begin
                        set_erase_err = 1'b1;
                    end else if (!vpp_ok) begin
                        set_erase_err = 1'b1;
                        set_vpp_err   = 1'b1;
                    end else begin
                        state_d     = ST_ERASING;
                        start_erase = 1'b1;
                    end
                end
            end
            ST_PROG_SETUP: begin
                if (we_ok) begin
                    if (!vpp_ok) begin
                        state_d      = ST_IDLE;
                        set_prog_err = 1'b1;
                        set_vpp_err  = 1'b1;
                    end else begin
                        state_d    = ST_PROG_PULSE;
                        start_prog = 1'b1;
                    end
                end
            end
            ST_ERASING: begin
                if (!vpp_ok) begin
                    state_d       = ST_IDLE;
                    set_erase_err = 1'b1;
                    set_vpp_err   = 1'b1;
                end else if (we_ok && bus_wdata == OP_SUSPEND) begin
                    state_d = ST_ERASE_SUSP;
                end else if (erase_last) begin
                    state_d = ST_IDLE;
                end
                if (we_ok && bus_wdata == OP_READ_STATUS) mode_d = RD_STATUS;
            end
            ST_ERASE_SUSP: begin
                if (we_ok) begin
                    case (bus_wdata)
                        OP_READ_ARRAY:  mode_d = RD_ARRAY;
                        OP_READ_IDENT:  mode_d = RD_IDENT;
                        OP_READ_STATUS: mode_d = RD_STATUS;
                        OP_CONFIRM: begin state_d = ST_ERASING; mode_d = RD_STATUS; end
                        default: ;
                    endcase
                end
            end
            ST_PROG_PULSE: begin
                if (!vpp_ok) begin
                    state_d      = ST_IDLE;
                    set_prog_err = 1'b1;
                    set_vpp_err  = 1'b1;
                end else if (timer_last) begin
                    pulse_fire = 1'b1;
                    state_d    = ST_PROG_VERIFY;
                end
            end
            ST_PROG_VERIFY: begin
                if (op_data == goal_q) begin
                    state_d = ST_IDLE;
                end else if (pulses_q == CNT_W'(MAX_PULSES)) begin
                    state_d      = ST_IDLE;
                    set_prog_err = 1'b1;
                end else begin
                    state_d = ST_PROG_PULSE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;   mode_q <= RD_ARRAY;   target_q <= BLK_MAIN;
            addr_q  <= '0;        goal_q <= '0;         timer_q  <= '0;
            pulses_q <= '0;
            err_erase_q <= 1'b0;  err_prog_q <= 1'b0;   err_vpp_q <= 1'b0;
        end else if (!pwd_n) begin
            state_q <= ST_IDLE;   mode_q <= RD_ARRAY;   target_q <= BLK_MAIN;
            addr_q  <= '0;        goal_q <= '0;         timer_q  <= '0;
            pulses_q <= '0;
            err_erase_q <= 1'b0;  err_prog_q <= 1'b0;   err_vpp_q <= 1'b0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
            if (clr_err) begin
                err_erase_q <= 1'b0;
                err_prog_q  <= 1'b0;
                err_vpp_q   <= 1'b0;
            end
            if (set_erase_err) err_erase_q <= 1'b1;
            if (set_prog_err)  err_prog_q  <= 1'b1;
            if (set_vpp_err)   err_vpp_q   <= 1'b1;
            if (start_erase) begin
                addr_q   <= '0;
                target_q <= addr_blk;
            end else if (start_prog) begin
                addr_q   <= bus_addr;
                goal_q   <= bus_wdata;
                pulses_q <= '0;
            end else if (state_q == ST_ERASING && state_d == ST_ERASING) begin
                addr_q <= addr_q + 1'b1;
            end
            if (state_q == ST_PROG_PULSE) timer_q <= pulse_fire ? '0 : timer_q + 1'b1;
            else                          timer_q <= '0;
            if (pulse_fire) pulses_q <= pulses_q + 1'b1;
        end
    end

    assign pending = op_data & ~goal_q;
    assign low_bit = pending & (~pending + 1'b1);

    always_comb begin
        op_addr = addr_q;
        rd_mode = mode_q;
        wr_en   = (state_q == ST_ERASING && vpp_ok && cur_blk == target_q) || pulse_fire;
        wr_data = (state_q == ST_ERASING) ? '1 : (op_data & ~low_bit);
        status  = {(state_q == ST_IDLE || state_q == ST_ERASE_SETUP ||
                    state_q == ST_PROG_SETUP || state_q == ST_ERASE_SUSP),
                   (state_q == ST_ERASE_SUSP),
                   err_erase_q, err_prog_q, err_vpp_q, 3'b000};
    end

    assert_erase_after_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERASING && $past(state_q) != ST_ERASING)
        |-> ($past(state_q) == ST_ERASE_SETUP || $past(state_q) == ST_ERASE_SUSP));

    assert_prog_after_setup_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG_PULSE && $past(state_q) != ST_PROG_PULSE)
        |-> ($past(state_q) == ST_PROG_SETUP || $past(state_q) == ST_PROG_VERIFY));

    assert_pulse_budget_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG_PULSE) |-> (pulses_q < CNT_W'(MAX_PULSES)));

    assert_no_write_low_vpp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !vpp_ok |-> !wr_en);

    assert_powerdown_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !pwd_n |=> (state_q == ST_IDLE && mode_q == RD_ARRAY &&
                    !err_erase_q && !err_prog_q && !err_vpp_q));

    assert_lockout_ignores_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!vcc_ok && pwd_n && state_q == ST_IDLE) |=> (state_q == ST_IDLE && $stable(mode_q)));

    assert_suspend_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERASE_SUSP && $past(state_q) == ST_ERASE_SUSP) |-> $stable(addr_q));

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import fcc_pkg::*;
#(
    parameter int          ADDR_W       = 10,
    parameter bit          TOP_BOOT     = 1'b1,
    parameter int          PULSE_CYCLES = 3,
    parameter int          MAX_PULSES   = 8,
    parameter logic [7:0]  MAKER_CODE   = 8'h5A,
    parameter logic [7:0]  DEV_CODE_TOP = 8'h3C,
    parameter logic [7:0]  DEV_CODE_BOT = 8'h3D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwd_n,
    input  logic              vpp_ok,
    input  logic              vcc_ok,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata
);
    localparam logic [7:0] DEV_CODE = TOP_BOOT ? DEV_CODE_TOP : DEV_CODE_BOT;

    blk_e              addr_blk, cur_blk;
    logic [ADDR_W-1:0] op_addr;
    logic [DW-1:0]     op_data, arr_rd, wr_data, status;
    logic              wr_en;
    rd_mode_e          rd_mode;

    fcc_block_decode #(.ADDR_W(ADDR_W), .TOP_BOOT(TOP_BOOT)) u_dec_bus (
        .addr (bus_addr),
        .blk  (addr_blk)
    );

    fcc_block_decode #(.ADDR_W(ADDR_W), .TOP_BOOT(TOP_BOOT)) u_dec_cur (
        .addr (op_addr),
        .blk  (cur_blk)
    );

    fcc_array #(.ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .rd_addr (bus_addr),
        .rd_data (arr_rd),
        .op_addr (op_addr),
        .op_data (op_data),
        .wr_en   (wr_en),
        .wr_data (wr_data)
    );

    fcc_wsm #(
        .ADDR_W       (ADDR_W),
        .PULSE_CYCLES (PULSE_CYCLES),
        .MAX_PULSES   (MAX_PULSES)
    ) u_wsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwd_n     (pwd_n),
        .vpp_ok    (vpp_ok),
        .vcc_ok    (vcc_ok),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .addr_blk  (addr_blk),
        .cur_blk   (cur_blk),
        .op_data   (op_data),
        .op_addr   (op_addr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_mode   (rd_mode),
        .status    (status)
    );

    always_comb begin
        if (!pwd_n) begin
            bus_rdata = '0;
        end else begin
            unique case (rd_mode)
                RD_ARRAY:  bus_rdata = arr_rd;
                RD_IDENT:  bus_rdata = bus_addr[0] ? DEV_CODE : MAKER_CODE;
                RD_STATUS: bus_rdata = status;
                default:   bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0, pwd_n = 1'b1, vpp_ok = 1'b1, vcc_ok = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;

    int  checks = 0, fails = 0;
    bit  done = 1'b0;
    logic [7:0] exp_mem [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_ctrl #(.ADDR_W(AW), .TOP_BOOT(1'b1), .PULSE_CYCLES(3), .MAX_PULSES(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwd_n(pwd_n), .vpp_ok(vpp_ok), .vcc_ok(vcc_ok),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [7:0] pat(int a);
        return 8'((a * 29 + 7) & 255);
    endfunction

    // 0 main, 1 low parameter slice, 2 high parameter slice, 3 boot (top-boot layout)
    function automatic int blk_of(int a);
        if (a >= (15 * N) / 16) return 3;
        if (a >= (29 * N) / 32) return 2;
        if (a >= (14 * N) / 16) return 1;
        return 0;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        bus_addr  = AW'(a);
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        bus_addr = AW'(a);
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_ready(input string req);
        logic [7:0] s;
        int n = 0;
        rd(0, s);
        while (!s[7] && n < 20000) begin
            @(negedge clk);
            rd(0, s);
            n++;
        end
        if (n >= 20000) check(req, s, 8'h80);
    endtask

    task automatic erase_block(input int a, input string req);
        logic [7:0] s;
        wr(0, 8'h20);
        wr(a, 8'hD0);
        rd(0, s);
        check(req, s & 8'h80, 8'h00);
        wait_ready(req);
        rd(0, s);
        check(req, s, 8'h80);
        for (int i = 0; i < N; i++) if (blk_of(i) == blk_of(a)) exp_mem[i] = 8'hFF;
    endtask

    task automatic program_byte(input int a, input logic [7:0] d, input logic [7:0] exp_stat,
                                input string req);
        logic [7:0] s;
        wr(0, 8'h40);
        wr(a, d);
        rd(0, s);
        check(req, s & 8'h80, 8'h00);
        wait_ready(req);
        rd(0, s);
        check(req, s, exp_stat);
        exp_mem[a] = exp_mem[a] & d;
    endtask

    task automatic sweep(input string req);
        logic [7:0] v;
        wr(0, 8'hFF);
        for (int i = 0; i < N; i++) begin
            rd(i, v);
            check(req, v, exp_mem[i]);
            @(negedge clk);
        end
    endtask

    initial begin
        logic [7:0] v, held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R2: status and identifier reads after reset
        wr(0, 8'h70); rd(0, v); check("R1", v, 8'h80);
        wr(0, 8'h90); rd(0, v); check("R2", v, 8'h5A);
        rd(1, v); check("R2", v, 8'h3C);

        // R4: blank every block
        erase_block(0, "R4");
        erase_block(896, "R4");
        erase_block(928, "R4");
        erase_block(960, "R4");

        // R6: fill whole array with a pattern
        for (int i = 0; i < N; i++) program_byte(i, pat(i), 8'h80, "R6");
        wr(0, 8'hFF); rd(5, v); check("R2", v, pat(5));
        sweep("R6");

        // R5: block boundaries, exhaustively
        erase_block(940, "R4");
        sweep("R5");
        erase_block(1000, "R4");
        sweep("R5");

        // R3 / R13: wrong confirm byte
        wr(0, 8'h20); wr(5, 8'h77);
        rd(0, v); check("R3", v, 8'hA0);
        wr(0, 8'hFF); rd(5, v); check("R3", v, exp_mem[5]);
        wr(0, 8'h90); wr(0, 8'h70); rd(0, v); check("R13", v, 8'hA0);
        wr(0, 8'h50); rd(0, v); check("R13", v, 8'h80);

        // R7: eight-bit clear succeeds, impossible target fails
        program_byte(970, 8'h00, 8'h80, "R7");
        program_byte(975, 8'h0F, 8'h80, "R7");
        program_byte(975, 8'hF0, 8'h90, "R7");
        wr(0, 8'hFF); rd(970, v); check("R7", v, 8'h00);
        rd(975, v); check("R7", v, 8'h00);
        wr(0, 8'h50);

        // R8: low program voltage
        vpp_ok = 1'b0;
        wr(0, 8'h20); wr(900, 8'hD0);
        rd(0, v); check("R8", v, 8'hA8);
        wr(0, 8'hFF); rd(900, v); check("R8", v, exp_mem[900]);
        wr(0, 8'h90); rd(0, v); check("R8", v, 8'h5A);
        wr(0, 8'h50);
        wr(0, 8'h40); wr(905, 8'h00);
        rd(0, v); check("R8", v, 8'h98);
        wr(0, 8'hFF); rd(905, v); check("R8", v, exp_mem[905]);
        wr(0, 8'h50);
        vpp_ok = 1'b1;

        // R9: voltage lost mid-erase
        wr(0, 8'h20); wr(10, 8'hD0);
        repeat (20) @(negedge clk);
        vpp_ok = 1'b0;
        @(negedge clk);
        rd(0, v); check("R9", v, 8'hA8);
        vpp_ok = 1'b1;
        wr(0, 8'h50); rd(0, v); check("R13", v, 8'h80);

        // R12: suspend, read elsewhere, resume
        wr(0, 8'h20); wr(10, 8'hD0);
        repeat (50) @(negedge clk);
        wr(0, 8'hB0);
        @(negedge clk);
        rd(0, v); check("R12", v, 8'hC0);
        wr(0, 8'hFF);
        rd(1000, v); check("R12", v, exp_mem[1000]);
        rd(800, held); check("R12", held, exp_mem[800]);
        repeat (2000) @(negedge clk);
        rd(800, v); check("R12", v, exp_mem[800]);
        wr(0, 8'h70); rd(0, v); check("R12", v, 8'hC0);
        wr(0, 8'hD0); rd(0, v); check("R12", v & 8'h80, 8'h00);
        wait_ready("R12");
        rd(0, v); check("R12", v, 8'h80);
        for (int i = 0; i < N; i++) if (blk_of(i) == 0) exp_mem[i] = 8'hFF;
        sweep("R12");

        // R11: supply lockout
        vcc_ok = 1'b0;
        wr(0, 8'h70);
        rd(900, v); check("R11", v, exp_mem[900]);
        wr(0, 8'h20); wr(900, 8'hD0);
        vcc_ok = 1'b1;
        wr(0, 8'h70); rd(0, v); check("R11", v, 8'h80);
        wr(0, 8'hFF); rd(900, v); check("R11", v, exp_mem[900]);

        // R10 / R1: powerdown abandons an erase
        wr(0, 8'h20); wr(3, 8'hD0);
        repeat (10) @(negedge clk);
        pwd_n = 1'b0;
        rd(1000, v); check("R10", v, 8'h00);
        wr(0, 8'h70);
        rd(0, v); check("R10", v, 8'h00);
        pwd_n = 1'b1;
        @(negedge clk);
        rd(1000, v); check("R1", v, exp_mem[1000]);
        wr(0, 8'h70); rd(0, v); check("R10", v, 8'h80);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(negedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule